// File: doc/BRIEF.md
# Text-Mode Grouped Fetch Sequencer

This block decides, for every position of a 1368-cycle display line, which video memory access a character-text display makes. It takes the current cycle count of the line and a column-width select (40 or 80 columns). It reports the access type, whether the access is part of a burst, the character group and the character within that group, and whether the data of the access is discarded. Address arithmetic, pixel shifting and the memory signalling are left to the blocks around it.

The line carries twenty groups of four characters, each group exactly 48 cycles long. A group opens with a four-read burst of character codes. One read of the blink-attribute byte follows, but only in every second group. Four separate glyph reads close the group; they cannot burst because each glyph may live in a different memory row. Outside the groups the block places seven closely packed refresh reads, two throw-away reads, and the processor/drawing-engine windows. In 40-column mode the cycle map does not change. Only the reads whose data is not needed are flagged as discarded.

The result is registered. The decode for the cycle count presented at one clock edge appears on the outputs after that edge.

Top module: `txt_fetch_seq`

## Requirements
- R1: While `rst_n` is low, the outputs are held at type IDLE (code 0), with `burst_o`, `group_o`, `char_o` and `discard_o` all zero.
- R2: The outputs are registered. They show the decode of the `cycle_i` value sampled at the previous rising edge and keep their value until the next edge.
- R3: Type NAME (code 4) appears at cycles g, g+4, g+8 and g+12, where g = 246 + 48k and k = 0..19. It has `burst_o` = 1, `group_o` = k and `char_o` = 0..3 in that order. That gives 80 per line. No other type ever sets `burst_o`.
- R4: Type COLOR (code 5) appears at g+18 only when k is even, with `group_o` = k, `char_o` = 0 and `burst_o` = 0. That gives 10 per line.
- R5: Type PATTERN (code 6) appears at g+24, g+30, g+36 and g+42, with `group_o` = k, `char_o` = 0..3 and `burst_o` = 0. That gives 80 per line.
- R6: Type REFRESH (code 2) appears at cycles 74 + 8j for j = 0..6 and nowhere else.
- R7: Type DUMMY (code 3) appears at cycles 230 and 238. It always has `discard_o` = 1.
- R8: Type CPU (code 1) appears at exactly 47 cycles per line, with zero group and character fields. The cycles are:
  - 2 + 8j, for j = 0..8
  - 166 + 8j, for j = 0..7
  - g+18 of each odd group k
  - 1206 + 8j, for j = 0..15
  - 1336
  - 1346, 1354 and 1362

  The largest distance between neighbouring CPU cycles is 100.
- R9: Every other cycle below 1368 is IDLE with all fields zero. Any `cycle_i` value of 1368 or above also gives IDLE.
- R10: With `wide_i` = 1 (80 columns), `discard_o` is 1 only for DUMMY.
- R11: With `wide_i` = 0 (40 columns), the types, burst, group and character outputs are identical to 80-column mode. In addition, `discard_o` is 1 for NAME and PATTERN reads with `char_o` of 2 or 3, and for every COLOR read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cycle_i | input | 11 | Cycle position within the display line |
| wide_i | input | 1 | 1 = 80 columns, 0 = 40 columns |
| acc_type_o | output | 3 | Access type code (0 IDLE, 1 CPU, 2 REFRESH, 3 DUMMY, 4 NAME, 5 COLOR, 6 PATTERN) |
| burst_o | output | 1 | Access belongs to a burst |
| group_o | output | 5 | Character group index of a group access |
| char_o | output | 2 | Character index within the group |
| discard_o | output | 1 | Data of this access is thrown away |

## Verification
The position g+18 is where two functions meet. The blink-attribute read in even groups and the processor window in odd groups are both decoded there. The fixed window runs also border the group area at cycles 222 and 1206.

The bench sweeps every cycle of the line in both width modes and compares each output against a slot map built by enumerating the groups and runs directly. This includes every g+18 position, so both outcomes of that shared position are judged. An assertion requires that at most one of the internal decode hits is raised in any cycle.

// File: rtl/txt_fetch_pkg.sv
package txt_fetch_pkg;

  typedef enum logic [2:0] {
    ACC_IDLE    = 3'd0,
    ACC_CPU     = 3'd1,
    ACC_REFRESH = 3'd2,
    ACC_DUMMY   = 3'd3,
    ACC_NAME    = 3'd4,
    ACC_COLOR   = 3'd5,
    ACC_PATTERN = 3'd6
  } acc_e;

  // True when c equals base + step*j for some j in 0..count-1.
  function automatic logic in_run(input int unsigned c, input int unsigned base,
                                  input int unsigned step, input int unsigned count);
    if (c < base) return 1'b0;
    if (((c - base) % step) != 0) return 1'b0;
    return ((c - base) / step) < count;
  endfunction

  // Offset within a periodic train: slot index, or -1 if not on the train.
  function automatic int train_index(input int unsigned rel, input int unsigned first,
                                     input int unsigned step, input int unsigned count);
    if (!in_run(rel, first, step, count)) return -1;
    return int'((rel - first) / step);
  endfunction

endpackage

// File: rtl/txt_group_decoder.sv
module txt_group_decoder
  import txt_fetch_pkg::*;
#(
  parameter int unsigned CW        = 11,
  parameter int unsigned BASE      = 246,
  parameter int unsigned SPAN      = 48,
  parameter int unsigned NGROUPS   = 20,
  parameter int unsigned CHARS     = 4,
  parameter int unsigned NAME_STEP = 4,
  parameter int unsigned COLOR_OFS = 18,
  parameter int unsigned PAT_OFS   = 24,
  parameter int unsigned PAT_STEP  = 6,
  localparam int unsigned GW       = $clog2(NGROUPS),
  localparam int unsigned XW       = $clog2(CHARS)
) (
  input  logic [CW-1:0] cycle_i,
  output logic          name_hit_o,
  output logic          color_hit_o,
  output logic          color_free_o,
  output logic          pat_hit_o,
  output logic [GW-1:0] group_o,
  output logic [XW-1:0] char_o
);

  localparam int unsigned WIN_END = BASE + SPAN * NGROUPS;

  int unsigned c_u;
  int unsigned off;
  int unsigned grp;
  int unsigned rel;
  int          name_idx;
  int          pat_idx;
  logic        in_win;

  always_comb begin
    c_u      = int'(cycle_i);
    in_win   = (c_u >= BASE) && (c_u < WIN_END);
    off      = in_win ? (c_u - BASE) : 0;
    grp      = off / SPAN;
    rel      = off % SPAN;
    name_idx = train_index(rel, 0, NAME_STEP, CHARS);
    pat_idx  = train_index(rel, PAT_OFS, PAT_STEP, CHARS);

    name_hit_o   = in_win && (name_idx >= 0);
    pat_hit_o    = in_win && (pat_idx >= 0);
    color_hit_o  = in_win && (rel == COLOR_OFS) && (grp[0] == 1'b0);
    color_free_o = in_win && (rel == COLOR_OFS) && (grp[0] == 1'b1);

    group_o = in_win ? GW'(grp) : '0;
    if (name_hit_o)      char_o = XW'(name_idx);
    else if (pat_hit_o)  char_o = XW'(pat_idx);
    else                 char_o = '0;
  end

endmodule

// File: rtl/txt_fixed_slots.sv
module txt_fixed_slots
  import txt_fetch_pkg::*;
#(
  parameter int unsigned CW        = 11,
  parameter int unsigned REF_BASE  = 74,
  parameter int unsigned REF_STEP  = 8,
  parameter int unsigned REF_COUNT = 7,
  parameter int unsigned DUM_BASE  = 230,
  parameter int unsigned DUM_STEP  = 8,
  parameter int unsigned DUM_COUNT = 2,
  parameter int unsigned NRUNS     = 5,
  parameter int unsigned RUN_BASE  [NRUNS] = '{2, 166, 1206, 1336, 1346},
  parameter int unsigned RUN_STEP  [NRUNS] = '{8, 8, 8, 8, 8},
  parameter int unsigned RUN_COUNT [NRUNS] = '{9, 8, 16, 1, 3}
) (
  input  logic [CW-1:0] cycle_i,
  output logic          refresh_hit_o,
  output logic          dummy_hit_o,
  output logic          cpu_hit_o
);

  logic [NRUNS-1:0] run_hit;

  for (genvar r = 0; r < NRUNS; r++) begin : g_cpu_run
    always_comb run_hit[r] = in_run(int'(cycle_i), RUN_BASE[r], RUN_STEP[r], RUN_COUNT[r]);
  end

  always_comb begin
    refresh_hit_o = in_run(int'(cycle_i), REF_BASE, REF_STEP, REF_COUNT);
    dummy_hit_o   = in_run(int'(cycle_i), DUM_BASE, DUM_STEP, DUM_COUNT);
    cpu_hit_o     = |run_hit;
  end

endmodule

// File: rtl/txt_fetch_seq.sv
module txt_fetch_seq
  import txt_fetch_pkg::*;
#(
  parameter int unsigned LINE_LEN = 1368,
  parameter int unsigned NGROUPS  = 20,
  parameter int unsigned CHARS    = 4,
  localparam int unsigned CW      = $clog2(LINE_LEN + 1),
  localparam int unsigned GW      = $clog2(NGROUPS),
  localparam int unsigned XW      = $clog2(CHARS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cycle_i,
  input  logic          wide_i,
  output logic [2:0]    acc_type_o,
  output logic          burst_o,
  output logic [GW-1:0] group_o,
  output logic [XW-1:0] char_o,
  output logic          discard_o
);

  // Named decode events, visible to the assertions below.
  logic          name_hit, color_hit, color_free, pat_hit;
  logic          refresh_hit, dummy_hit, cpu_run_hit;
  logic [GW-1:0] dec_group;
  logic [XW-1:0] dec_char;
  logic          in_line;
  logic          upper_char;

  txt_group_decoder #(.CW(CW), .NGROUPS(NGROUPS), .CHARS(CHARS)) u_groups (
    .cycle_i     (cycle_i),
    .name_hit_o  (name_hit),
    .color_hit_o (color_hit),
    .color_free_o(color_free),
    .pat_hit_o   (pat_hit),
    .group_o     (dec_group),
    .char_o      (dec_char)
  );

  txt_fixed_slots #(.CW(CW)) u_fixed (
    .cycle_i      (cycle_i),
    .refresh_hit_o(refresh_hit),
    .dummy_hit_o  (dummy_hit),
    .cpu_hit_o    (cpu_run_hit)
  );

  acc_e          nxt_type;
  logic          nxt_burst, nxt_disc;
  logic [GW-1:0] nxt_grp;
  logic [XW-1:0] nxt_chr;

  always_comb begin
    in_line    = int'(cycle_i) < LINE_LEN;
    upper_char = dec_char >= XW'(CHARS / 2);
    nxt_type   = ACC_IDLE;
    nxt_burst  = 1'b0;
    nxt_grp    = '0;
    nxt_chr    = '0;
    nxt_disc   = 1'b0;
    if (in_line) begin
      if (name_hit) begin
        nxt_type  = ACC_NAME;
        nxt_burst = 1'b1;
        nxt_grp   = dec_group;
        nxt_chr   = dec_char;
        nxt_disc  = !wide_i && upper_char;
      end else if (color_hit) begin
        nxt_type = ACC_COLOR;
        nxt_grp  = dec_group;
        nxt_disc = !wide_i;
      end else if (pat_hit) begin
        nxt_type = ACC_PATTERN;
        nxt_grp  = dec_group;
        nxt_chr  = dec_char;
        nxt_disc = !wide_i && upper_char;
      end else if (refresh_hit) begin
        nxt_type = ACC_REFRESH;
      end else if (dummy_hit) begin
        nxt_type = ACC_DUMMY;
        nxt_disc = 1'b1;
      end else if (cpu_run_hit || color_free) begin
        nxt_type = ACC_CPU;
      end
    end
  end

  logic wide_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_type_o <= ACC_IDLE;
      burst_o    <= 1'b0;
      group_o    <= '0;
      char_o     <= '0;
      discard_o  <= 1'b0;
      wide_q     <= 1'b1;
    end else begin
      acc_type_o <= nxt_type;
      burst_o    <= nxt_burst;
      group_o    <= nxt_grp;
      char_o     <= nxt_chr;
      discard_o  <= nxt_disc;
      wide_q     <= wide_i;
    end
  end

  // R9: the decoders never claim the same cycle twice.
  a_r9_single_source: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({name_hit, color_hit, color_free, pat_hit, refresh_hit, dummy_hit, cpu_run_hit}));

  a_r3_burst_only_name: assert property (@(posedge clk) disable iff (!rst_n)
    burst_o |-> acc_type_o == ACC_NAME);

  a_r3_name_is_burst: assert property (@(posedge clk) disable iff (!rst_n)
    acc_type_o == ACC_NAME |-> burst_o);

  a_r4_color_even_group: assert property (@(posedge clk) disable iff (!rst_n)
    acc_type_o == ACC_COLOR |-> !group_o[0]);

  a_r7_dummy_discard: assert property (@(posedge clk) disable iff (!rst_n)
    acc_type_o == ACC_DUMMY |-> discard_o);

  a_r10_wide_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_q && acc_type_o != ACC_DUMMY) |-> !discard_o);

  a_r2_refresh_latency: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_hit && in_line |=> acc_type_o == ACC_REFRESH);

endmodule

// File: tb/txt_fetch_seq_tb.sv
module txt_fetch_seq_tb;

  localparam int LINE = 1368;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] cycle_i = '0;
  logic        wide_i = 1'b1;
  logic [2:0]  acc_type_o;
  logic        burst_o;
  logic [4:0]  group_o;
  logic [1:0]  char_o;
  logic        discard_o;

  int checks = 0;
  int errors = 0;
  int exp_t [LINE];
  int exp_g [LINE];
  int exp_c [LINE];

  always #2 clk = ~clk;

  txt_fetch_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cycle_i(cycle_i), .wide_i(wide_i),
    .acc_type_o(acc_type_o), .burst_o(burst_o), .group_o(group_o),
    .char_o(char_o), .discard_o(discard_o)
  );

  function automatic string req_of(input int t);
    case (t)
      1: return "R8";
      2: return "R6";
      3: return "R7";
      4: return "R3";
      5: return "R4";
      6: return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int c);
    @(negedge clk);
    cycle_i = 11'(c);
    @(posedge clk);
    #1;
  endtask

  task automatic build_map();
    for (int c = 0; c < LINE; c++) begin
      exp_t[c] = 0; exp_g[c] = 0; exp_c[c] = 0;
    end
    for (int j = 0; j < 7; j++) exp_t[74 + 8*j] = 2;   // R6
    exp_t[230] = 3; exp_t[238] = 3;                     // R7
    for (int j = 0; j < 9; j++)  exp_t[2 + 8*j] = 1;    // R8
    for (int j = 0; j < 8; j++)  exp_t[166 + 8*j] = 1;
    for (int j = 0; j < 16; j++) exp_t[1206 + 8*j] = 1;
    exp_t[1336] = 1;
    for (int j = 0; j < 3; j++)  exp_t[1346 + 8*j] = 1;
    for (int k = 0; k < 20; k++) begin
      int g;
      g = 246 + 48*k;
      for (int i = 0; i < 4; i++) begin
        exp_t[g + 4*i] = 4;  exp_g[g + 4*i] = k;  exp_c[g + 4*i] = i;    // R3
        exp_t[g + 24 + 6*i] = 6; exp_g[g + 24 + 6*i] = k; exp_c[g + 24 + 6*i] = i; // R5
      end
      if (k % 2 == 0) begin exp_t[g + 18] = 5; exp_g[g + 18] = k; end     // R4
      else exp_t[g + 18] = 1;                                            // R8
    end
  endtask

  task automatic sweep(input bit wide);
    int cnt [7];
    int last_cpu, max_gap;
    for (int t = 0; t < 7; t++) cnt[t] = 0;
    last_cpu = -1; max_gap = 0;
    wide_i = wide;
    for (int c = 0; c < LINE; c++) begin
      int t;
      bit ed;
      step(c);
      t = exp_t[c];
      ed = (t == 3) || (!wide && ((t == 5) || ((t == 4 || t == 6) && exp_c[c] >= 2)));
      checks++;
      if (int'(acc_type_o) != t || burst_o != (t == 4) || int'(group_o) != exp_g[c] ||
          int'(char_o) != exp_c[c] || discard_o != ed) begin
        errors++;
        $display("FAIL %s %s cycle %0d actual t=%0d b=%0d g=%0d c=%0d d=%0d expected t=%0d b=%0d g=%0d c=%0d d=%0d",
                 req_of(t), wide ? "R10" : "R11", c, acc_type_o, burst_o, group_o, char_o,
                 discard_o, t, t == 4, exp_g[c], exp_c[c], ed);
      end
      cnt[acc_type_o]++;
      if (acc_type_o == 3'd1) begin
        if (last_cpu >= 0 && c - last_cpu > max_gap) max_gap = c - last_cpu;
        last_cpu = c;
      end
    end
    check("R3", cnt[4], 80, "name reads per line");
    check("R5", cnt[6], 80, "pattern reads per line");
    check("R4", cnt[5], 10, "colour reads per line");
    check("R6", cnt[2], 7, "refresh reads per line");
    check("R7", cnt[3], 2, "dummy reads per line");
    check("R8", cnt[1], 47, "cpu slots per line");
    check("R8", max_gap, 100, "largest cpu gap");
  endtask

  bit done = 1'b0;

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    build_map();
    cycle_i = 11'd74;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset holds idle even with a refresh cycle presented
    check("R1", int'(acc_type_o), 0, "type in reset");
    check("R1", int'({burst_o, group_o, char_o, discard_o}), 0, "fields in reset");
    @(negedge clk);
    rst_n = 1'b1;
    step(0);
    // R2: new cycle presented, output unchanged before the edge
    @(negedge clk);
    cycle_i = 11'd74;
    #1;
    check("R2", int'(acc_type_o), 0, "before edge");
    @(posedge clk);
    #1;
    check("R2", int'(acc_type_o), 2, "after edge");
    #2;
    check("R2", int'(acc_type_o), 2, "held to next edge");
    sweep(1'b1);   // R10
    sweep(1'b0);   // R11
    // R9: out-of-range cycle counts
    step(1368);
    check("R9", int'(acc_type_o), 0, "cycle 1368");
    step(2047);
    check("R9", int'(acc_type_o), 0, "cycle 2047");
    check("R9", int'({burst_o, group_o, char_o, discard_o}), 0, "fields at 2047");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule